// File: doc/BRIEF.md
# Converter Result Serial Port

This block is the device-side serial read port of a measuring converter. A finished measurement arrives as a signed raw value with a one-cycle done strobe. The block limits the value to the converter's output code range and keeps it until a host reads it out over an SPI-style link. The host drives an active-low select and a serial clock. The block drives a serial data line together with its output enable.

While the host holds select low, the data line first shows a live, active-low ready flag. It stays high while a conversion is running and drops as soon as a result is waiting. The host then clocks out a 24-bit frame, most significant bit first. Each bit is launched on a falling serial-clock edge and is meant to be sampled on the next rising edge. The final falling edge closes the frame. It returns the line high and emits a one-cycle request to start the next conversion, and that high level is the next frame's ready flag.

The serial clock and select are brought into the system clock domain through synchronisers. The system clock must run at least eight times faster than the serial clock. A behavioural timer in the bench stands in for the conversion time.

Top module: `conv_result_port`

## Requirements
- R1: While cs_n is high, sdo_oe is low, and serial-clock edges do not advance the frame: the next selection still starts from bit 23.
- R2: While cs_n is low, sdo_oe is high in the same cycle. Before the first falling edge, sdo_d shows the ready flag: 1 while converting, and 0 from the cycle after an accepted conv_done.
- R3: The frame is 24 bits sent MSB first. Bit 23 is the ready flag (0), bits 22..18 are 0, and bits 17..0 hold the 18-bit two's-complement result code. Bit 23-n appears on sdo_d within three system clocks after the n-th falling sck edge.
- R4: The 24th falling sck edge drives sdo_d to 1 and produces a one-cycle conv_start pulse.
- R5: A raw value above +FS (131070) is coded as +FS+1 (131071).
- R6: A raw value below -FS is coded as -FS-1 (-131071).
- R7: Raw values from -FS to +FS, limits included, are coded unchanged.
- R8: A conv_done that arrives while a result is waiting unread is ignored, and the waiting result is the one read out.
- R9: Raising cs_n before the 24th falling edge aborts the frame. The same result is then read in full at the next selection.
- R10: Falling sck edges while converting do not start a frame. This includes an edge acted on in the same cycle as conv_done; the frame starts at the next falling edge.
- R11: conv_start pulses for one cycle in the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_raw | input | 20 | Signed raw measurement, sampled with conv_done |
| conv_done | input | 1 | One-cycle strobe: measurement finished |
| conv_start | output | 1 | One-cycle pulse: begin next conversion |
| cs_n | input | 1 | Active-low select from host |
| sck | input | 1 | Serial clock from host |
| sdo_d | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data drive enable; low means high impedance |

## Verification
A done strobe and a synchronised falling sck edge can be acted on in the same clock while a conversion is running. The edge must be judged against the busy state that held before the strobe, so it must not start a frame. The bench provokes this by raising conv_done exactly two clocks after it lowers sck, which is the cycle the edge reaches the frame logic. A bench model running alongside the design checks that the line shows bit 23 until the next falling edge, and that the following 24 pulses capture the complete frame.

// File: rtl/crp_pkg.sv
package crp_pkg;

   // Synchronised serial-clock view handed to the frame logic
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } crp_edge_t;

   // Width of a counter that must hold 0 .. n-1
   function automatic int crp_cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/crp_sync.sv
module crp_sync #(
   parameter int STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck_pin,
   input  logic                cs_n_pin,
   output crp_pkg::crp_edge_t  sck_evt,
   output logic                selected
);

   if (STAGES < 2) begin : g_chk_stages
      $error("crp_sync: STAGES below 2");
   end

   logic [STAGES:0]   sck_sr;
   logic [STAGES-1:0] cs_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sr <= '0;
         cs_sr  <= '1;
      end else begin
         sck_sr <= {sck_sr[STAGES-1:0], sck_pin};
         cs_sr  <= {cs_sr[STAGES-2:0], cs_n_pin};
      end
   end

   always_comb begin
      sck_evt.level = sck_sr[STAGES-1];
      sck_evt.rise  = sck_sr[STAGES-1] & ~sck_sr[STAGES];
      sck_evt.fall  = ~sck_sr[STAGES-1] & sck_sr[STAGES];
   end

   assign selected = ~cs_sr[STAGES-1];

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sck_evt.fall |=> !sck_evt.fall); // R3

endmodule

// File: rtl/crp_clamp.sv
module crp_clamp #(
   parameter int RAW_W  = 20,
   parameter int CODE_W = 18,
   parameter int FS     = 131070
) (
   input  logic signed [RAW_W-1:0]  raw,
   output logic signed [CODE_W-1:0] code
);

   localparam int  EXT_W   = ((RAW_W > CODE_W) ? RAW_W : CODE_W) + 1;
   localparam longint CODE_MAX = (longint'(1) <<< (CODE_W-1)) - 1;
   localparam longint RAW_MAX  = (longint'(1) <<< (RAW_W-1)) - 1;

   if (FS < 1) begin : g_chk_fs_low
      $error("crp_clamp: FS must be positive");
   end
   if (longint'(FS) + 1 > CODE_MAX) begin : g_chk_fs_high
      $error("crp_clamp: FS+1 does not fit the code width");
   end

   if ((RAW_W < CODE_W) && (RAW_MAX <= longint'(FS))) begin : g_pass
      // Raw range lies inside full scale: plain sign extension
      assign code = {{(CODE_W-RAW_W){raw[RAW_W-1]}}, raw};
   end else begin : g_sat
      localparam logic signed [EXT_W-1:0] HI = EXT_W'(FS);
      localparam logic signed [EXT_W-1:0] LO = -HI;
      logic signed [EXT_W-1:0] ext;
      assign ext = {{(EXT_W-RAW_W){raw[RAW_W-1]}}, raw};
      always_comb begin
         if (ext > HI)      code = CODE_W'(HI + EXT_W'(1));
         else if (ext < LO) code = CODE_W'(LO - EXT_W'(1));
         else               code = CODE_W'(ext);
      end
   end

   always_comb begin
      if (!$isunknown(raw)) begin
         AST_CODE_RANGE: assert ((longint'(code) <= longint'(FS) + 1) &&
                                 (longint'(code) >= -longint'(FS) - 1)); // R5
      end
   end

endmodule

// File: rtl/crp_shift.sv
module crp_shift #(
   parameter int FRAME_W = 24,
   parameter int CODE_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     restore,
   input  logic                     advance,
   input  logic signed [CODE_W-1:0] code_in,
   output logic                     msb
);

   localparam int SH_W  = FRAME_W - 1;
   localparam int PAD_W = SH_W - CODE_W;

   if (PAD_W < 0) begin : g_chk_fit
      $error("crp_shift: code wider than frame payload");
   end

   logic [CODE_W-1:0] result_q;
   logic [SH_W-1:0]   sh_q;
   logic [SH_W-1:0]   word_new;
   logic [SH_W-1:0]   word_keep;

   if (PAD_W > 0) begin : g_pad
      assign word_new  = {{PAD_W{1'b0}}, code_in};
      assign word_keep = {{PAD_W{1'b0}}, result_q};
   end else begin : g_nopad
      assign word_new  = code_in;
      assign word_keep = result_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         sh_q     <= '0;
      end else if (load) begin
         result_q <= code_in;
         sh_q     <= word_new;
      end else if (restore) begin
         sh_q     <= word_keep;
      end else if (advance) begin
         sh_q     <= {sh_q[SH_W-2:0], 1'b0};
      end
   end

   assign msb = sh_q[SH_W-1];

   AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (msb == $past(word_new[SH_W-1]))); // R3

endmodule

// File: rtl/conv_result_port.sv
module conv_result_port #(
   parameter int FRAME_W     = 24,
   parameter int CODE_W      = 18,
   parameter int RAW_W       = 20,
   parameter int FS          = 131070,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [RAW_W-1:0] conv_raw,
   input  logic                    conv_done,
   output logic                    conv_start,
   input  logic                    cs_n,
   input  logic                    sck,
   output logic                    sdo_d,
   output logic                    sdo_oe
);

   import crp_pkg::*;

   localparam int CNT_W = crp_cnt_w(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

   if (FRAME_W < 3) begin : g_chk_frame
      $error("conv_result_port: frame too short");
   end

   crp_edge_t           evt;
   logic                sel;
   logic signed [CODE_W-1:0] code;
   logic                sh_msb;

   logic                eoc_n_q;
   logic                boot_q;
   logic                start_q;
   logic [CNT_W-1:0]    cnt_q;

   logic                accept;
   logic                step;
   logic                last;

   crp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_pin  (sck),
      .cs_n_pin (cs_n),
      .sck_evt  (evt),
      .selected (sel)
   );

   crp_clamp #(.RAW_W(RAW_W), .CODE_W(CODE_W), .FS(FS)) u_clamp (
      .raw  (conv_raw),
      .code (code)
   );

   // A result is taken only while converting; a waiting one is kept
   assign accept = conv_done & eoc_n_q;
   // Falling edge counts once a result is ready or a frame is under way
   assign step   = sel & evt.fall & ((cnt_q != '0) | ~eoc_n_q);
   assign last   = step & (cnt_q == LAST_IDX);

   crp_shift #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .restore (~sel),
      .advance (step & (cnt_q != '0)),
      .code_in (code),
      .msb     (sh_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_n_q <= 1'b1;
         boot_q  <= 1'b1;
         start_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         boot_q  <= 1'b0;
         start_q <= boot_q | last;
         if (!sel || last)   cnt_q <= '0;
         else if (step)      cnt_q <= cnt_q + CNT_W'(1);
         if (last)           eoc_n_q <= 1'b1;
         else if (accept)    eoc_n_q <= 1'b0;
      end
   end

   assign conv_start = start_q;
   assign sdo_d      = (cnt_q == '0) ? eoc_n_q : sh_msb;
   assign sdo_oe     = ~cs_n;

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && eoc_n_q) |=> !eoc_n_q); // R2
   AST_FRAME_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (eoc_n_q && conv_start && (cnt_q == '0))); // R4
   AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_n_q && (cnt_q == '0)) |=> (cnt_q == '0)); // R10
   AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!eoc_n_q && !last) |=> !eoc_n_q); // R8
   AST_DESEL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (sdo_d == eoc_n_q)); // R9
   AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R11

endmodule

// File: tb/tb_conv_result_port.sv
module tb_conv_result_port;

   localparam int CLK_PERIOD = 10;
   localparam int PH         = 4;       // system clocks per sck phase
   localparam int FS         = 131070;
   localparam int WD_LIMIT   = 60000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [19:0] conv_raw = '0;
   logic               conv_done = 1'b0;
   logic               conv_start;
   logic               cs_n = 1'b1;
   logic               sck = 1'b0;
   logic               sdo_d;
   logic               sdo_oe;

   int    vectors = 0;
   int    fails = 0;
   int    starts = 0;
   string cur_req = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_result_port dut (
      .clk(clk), .rst_n(rst_n), .conv_raw(conv_raw), .conv_done(conv_done),
      .conv_start(conv_start), .cs_n(cs_n), .sck(sck), .sdo_d(sdo_d), .sdo_oe(sdo_oe)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sat(input int r);
      if (r > FS)  return FS + 1;
      if (r < -FS) return -FS - 1;
      return r;
   endfunction

   function automatic logic [23:0] frame_of(input int code);
      logic [17:0] c;
      c = code[17:0];
      return {6'b0, c};
   endfunction

   // ---------------- behavioural reference model ----------------
   bit m_sk1, m_sk2, m_sk3, m_cs1, m_cs2;
   bit m_eoc, m_boot, m_start;
   int m_cnt, m_result;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sk1 = 0; m_sk2 = 0; m_sk3 = 0; m_cs1 = 1; m_cs2 = 1;
         m_eoc = 1; m_boot = 1; m_start = 0; m_cnt = 0; m_result = 0;
      end else begin
         bit sel_now, fall_now, go, old_eoc;
         sel_now  = !m_cs2;
         fall_now = m_sk3 && !m_sk2;
         old_eoc  = m_eoc;
         go       = sel_now && fall_now && (m_cnt != 0 || !old_eoc);
         m_start  = m_boot || (go && m_cnt == 23);
         m_boot   = 0;
         if (go && m_cnt == 23) m_eoc = 1;
         else if (conv_done && old_eoc) begin
            m_eoc = 0;
            m_result = sat(int'(conv_raw));
         end
         if (!sel_now)    m_cnt = 0;
         else if (go)     m_cnt = (m_cnt == 23) ? 0 : m_cnt + 1;
         m_sk3 = m_sk2; m_sk2 = m_sk1; m_sk1 = sck;
         m_cs2 = m_cs1; m_cs1 = cs_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [23:0] f;
         bit exp_d;
         f = frame_of(m_result);
         exp_d = (m_cnt == 0) ? m_eoc : f[23 - m_cnt];
         check({cur_req, " sdo_oe"}, sdo_oe, !cs_n);
         if (!cs_n) check({cur_req, " sdo_d"}, sdo_d, exp_d);
         check({cur_req, " conv_start"}, conv_start, m_start);
         if (conv_start) starts++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic done_pulse(input int raw);
      conv_raw = 20'(raw);
      conv_done = 1'b1;
      tick(1);
      conv_done = 1'b0;
      tick(1);
   endtask

   task automatic select(input bit on);
      cs_n = !on;
      tick(PH);
   endtask

   task automatic pulses(input int n, output logic [23:0] word);
      word = '0;
      for (int i = 0; i < n; i++) begin
         sck = 1'b1;
         if (i < 24) word[23 - i] = sdo_d;
         tick(PH);
         sck = 1'b0;
         tick(PH);
      end
   endtask

   task automatic read_check(input string tag, input int raw);
      logic [23:0] w;
      int s0;
      s0 = starts;
      pulses(24, w);
      check({tag, " frame"}, w, frame_of(sat(raw)));
      check("R4 line high after frame", sdo_d, 1);
      check("R4 start pulse count", starts - s0, 1);
   endtask

   task automatic run();
      logic [23:0] junk;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      check("R11 start after reset", starts, 1);
      check("R1 idle enable", sdo_oe, 0);

      cur_req = "R2";
      select(1);
      check("R2 busy flag", sdo_d, 1);
      cur_req = "R10";
      pulses(3, junk);
      check("R10 busy edges ignored", sdo_d, 1);
      cur_req = "R2";
      done_pulse(1234);
      check("R2 ready flag", sdo_d, 0);
      cur_req = "R3";
      read_check("R3 R7", 1234);

      cur_req = "R1";
      done_pulse(-5000);
      select(0);
      check("R1 enable off", sdo_oe, 0);
      pulses(5, junk);
      select(1);
      check("R1 still at flag", sdo_d, 0);
      read_check("R1", -5000);

      cur_req = "R7";
      done_pulse(FS);       read_check("R7 +FS", FS);
      done_pulse(-FS);      read_check("R7 -FS", -FS);
      cur_req = "R5";
      done_pulse(500000);   read_check("R5 far above", 500000);
      done_pulse(FS + 1);   read_check("R5 just above", FS + 1);
      cur_req = "R6";
      done_pulse(-500000);  read_check("R6 far below", -500000);
      done_pulse(-FS - 2);  read_check("R6 just below", -FS - 2);

      cur_req = "R8";
      done_pulse(777);
      done_pulse(888);
      read_check("R8 first kept", 777);

      cur_req = "R9";
      done_pulse(4242);
      pulses(10, junk);
      check("R9 partial bits", junk[23:14], frame_of(4242) >> 14);
      select(0);
      select(1);
      check("R9 back at flag", sdo_d, 0);
      read_check("R9 reread", 4242);

      cur_req = "R10";
      sck = 1'b1;
      tick(PH);
      sck = 1'b0;
      tick(2);
      conv_raw = 20'(99);
      conv_done = 1'b1;
      tick(1);
      conv_done = 1'b0;
      tick(PH);
      check("R10 coincident edge left flag", sdo_d, 0);
      read_check("R10 full frame", 99);
      tick(4);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (WD_LIMIT) @(posedge clk);
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule